// File: doc/BRIEF.md
# Masked Device Interrupt Router

The router gathers up to 64 device interrupt request lines into one shared request vector and routes them to up to four CPUs. Devices raise a request with a post strobe and withdraw it with a clear strobe; each strobe carries an interrupt number. Every CPU owns a private enable mask. Its effective pending set is the bitwise AND of that mask with the shared request vector. The block keeps that set current after every mask write and every device post or clear.

Each CPU receives a level interrupt that is high while its effective set is non-empty. Two one-cycle event pulses per CPU report when a pending bit appears and when one is withdrawn. Software reaches the request vector, the masks and the effective sets through a simple 64-bit register port with a one-cycle read latency. The masks are writable. The request vector and the effective sets are read-only. Illegal accesses raise a one-cycle error flag and change no state.

Top module: `mdir_router`

## Requirements
- R1: After a synchronous active-high reset, the request vector, all masks and all effective sets are zero, and `cpu_irq`, `irq_raise`, `irq_drop` and `reg_err` are low.
- R2: The register index is `reg_addr[ADDR_W-1:6]`, which places registers on 64-byte strides. Index 0 holds the request vector, index 8+c holds the mask of CPU c, and index 16+c holds the effective set of CPU c. A read returns its data on `reg_rdata` in the cycle after `reg_rd`, taken from the state before any update made in the same cycle.
- R3: `dev_post` with `post_num`=n sets request bit n, and `dev_clear` with `clr_num`=n clears it. When a post and a clear of the same number arrive in one cycle, the bit ends up set.
- R4: After every update, the effective set of CPU c equals mask c AND the request vector.
- R5: `cpu_irq[c]` is the OR of CPU c's effective set. It changes in the cycle after the strobe or write that causes the change.
- R6: `irq_raise[c]` pulses for one cycle after any event that newly sets a bit of CPU c's effective set. It also pulses after any post whose number is enabled in mask c, even when that request is already pending.
- R7: `irq_drop[c]` pulses for one cycle after any event that removes a bit from CPU c's effective set.
- R8: A clear of a request bit that is not set is spurious. It changes no state and produces no `irq_drop` pulse and no change in `cpu_irq`.
- R9: A device post and a mask write in the same cycle both take effect, and the new effective set reflects both the new mask and the new request bit.
- R10: A write to the request vector or to an effective set pulses `reg_err` in the next cycle and leaves all state unchanged.
- R11: The following accesses pulse `reg_err` for one cycle and leave state unchanged: an access with `reg_full` low, an access whose `reg_addr[5:0]` is non-zero, and an access to an index with no register. Such a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_post | input | 1 | Device request post strobe |
| post_num | input | NUM_W | Interrupt number of the post |
| dev_clear | input | 1 | Device request clear strobe |
| clr_num | input | NUM_W | Interrupt number of the clear |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_full | input | 1 | Access is a full 64-bit access |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | LINES | Write data |
| reg_rdata | output | LINES | Read data, one cycle after reg_rd |
| reg_err | output | 1 | One-cycle error flag for an illegal access |
| cpu_irq | output | NUM_CPUS | Level interrupt per CPU |
| irq_raise | output | NUM_CPUS | Pulse: a pending bit was signalled to the CPU |
| irq_drop | output | NUM_CPUS | Pulse: a pending bit was withdrawn from the CPU |

## Verification
The hardest situations to reach from the ports are the coincidences: a post landing in the same cycle as a mask write that enables it, a post and a clear of the same number, and a re-post of a request that is already pending. In each of these the effective set changes, or stays the same, through two paths at once. The bench drives these strobes together in a single cycle against a model that applies the clear, then the post, then the mask. Before those cases, full sweeps post every line number and then clear every even number twice. The second pass turns each clear into a spurious one, and the bench compares the irq, raise and drop vectors of all four CPUs after each event.

// File: rtl/mdir_pkg.sv
package mdir_pkg;
  localparam int IDX_REQ       = 0;
  localparam int IDX_MASK_BASE = 8;
  localparam int IDX_EFF_BASE  = 16;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_REQ  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_EFF  = 2'd3
  } sel_e;
endpackage

// File: rtl/mdir_decode.sv
module mdir_decode
  import mdir_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int ADDR_W   = 12,
  parameter int CPU_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              full,
  output sel_e              sel,
  output logic [CPU_W-1:0]  cpu,
  output logic              mask_we,
  output logic              rd_ok,
  output logic              err
);
  localparam int IDX_W = ADDR_W - 6;
  localparam logic [IDX_W-1:0] I_REQ = IDX_W'(IDX_REQ);
  localparam logic [IDX_W-1:0] I_MB  = IDX_W'(IDX_MASK_BASE);
  localparam logic [IDX_W-1:0] I_EB  = IDX_W'(IDX_EFF_BASE);
  localparam logic [IDX_W-1:0] I_N   = IDX_W'(NUM_CPUS);

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             legal;
  logic             rd_bad;
  logic             wr_bad;

  assign idx     = addr[ADDR_W-1:6];
  assign aligned = (addr[5:0] == 6'd0);

  always_comb begin
    sel = SEL_NONE;
    cpu = '0;
    if (aligned) begin
      if (idx == I_REQ) begin
        sel = SEL_REQ;
      end else if (idx >= I_MB && idx < I_MB + I_N) begin
        sel = SEL_MASK;
        cpu = CPU_W'(idx - I_MB);
      end else if (idx >= I_EB && idx < I_EB + I_N) begin
        sel = SEL_EFF;
        cpu = CPU_W'(idx - I_EB);
      end
    end
  end

  assign legal   = full && (sel != SEL_NONE);
  assign rd_bad  = rd && !legal;
  assign wr_bad  = wr && !(legal && sel == SEL_MASK);
  assign rd_ok   = rd && legal;
  assign mask_we = wr && legal && (sel == SEL_MASK);
  assign err     = rd_bad || wr_bad;
endmodule

// File: rtl/mdir_request.sv
module mdir_request #(
  parameter int LINES = 64,
  parameter int NUM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             post,
  input  logic [NUM_W-1:0] post_num,
  input  logic             clr,
  input  logic [NUM_W-1:0] clr_num,
  output logic [LINES-1:0] req_q,
  output logic [LINES-1:0] req_n
);
  // Clear is applied first so a same-number post wins.
  always_comb begin
    req_n = req_q;
    if (clr)  req_n[clr_num]  = 1'b0;
    if (post) req_n[post_num] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req_n;
  end
endmodule

// File: rtl/mdir_cpu_lane.sv
module mdir_cpu_lane #(
  parameter int LINES = 64,
  parameter int NUM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] req_n,
  input  logic             post,
  input  logic [NUM_W-1:0] post_num,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] eff_q,
  output logic             irq,
  output logic             raise,
  output logic             drop
);
  logic [LINES-1:0] mask_n;
  logic [LINES-1:0] eff_n;
  logic [LINES-1:0] gained;
  logic [LINES-1:0] lost;
  logic             repost;

  assign mask_n = mask_we ? wdata : mask_q;
  assign eff_n  = mask_n & req_n;
  assign gained = eff_n & ~eff_q;
  assign lost   = eff_q & ~eff_n;
  assign repost = post && mask_n[post_num];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      eff_q  <= '0;
      irq    <= 1'b0;
      raise  <= 1'b0;
      drop   <= 1'b0;
    end else begin
      mask_q <= mask_n;
      eff_q  <= eff_n;
      irq    <= |eff_n;
      raise  <= (|gained) || repost;
      drop   <= |lost;
    end
  end
endmodule

// File: rtl/mdir_router.sv
module mdir_router
  import mdir_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int LINES    = 64,
  parameter int ADDR_W   = 12,
  localparam int NUM_W   = $clog2(LINES),
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dev_post,
  input  logic [NUM_W-1:0]    post_num,
  input  logic                dev_clear,
  input  logic [NUM_W-1:0]    clr_num,
  input  logic                reg_rd,
  input  logic                reg_wr,
  input  logic                reg_full,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [LINES-1:0]    reg_wdata,
  output logic [LINES-1:0]    reg_rdata,
  output logic                reg_err,
  output logic [NUM_CPUS-1:0] cpu_irq,
  output logic [NUM_CPUS-1:0] irq_raise,
  output logic [NUM_CPUS-1:0] irq_drop
);
  sel_e                       sel;
  logic [CPU_W-1:0]           dcpu;
  logic                       mask_we;
  logic                       rd_ok;
  logic                       err_n;
  logic [LINES-1:0]           req_q;
  logic [LINES-1:0]           req_n;
  logic [LINES-1:0]           mask_arr [NUM_CPUS];
  logic [LINES-1:0]           eff_arr  [NUM_CPUS];
  logic [NUM_CPUS*LINES-1:0]  mask_flat;
  logic [NUM_CPUS*LINES-1:0]  eff_flat;
  logic [LINES-1:0]           rd_val;

  mdir_decode #(
    .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W), .CPU_W(CPU_W)
  ) u_dec (
    .addr(reg_addr), .rd(reg_rd), .wr(reg_wr), .full(reg_full),
    .sel(sel), .cpu(dcpu), .mask_we(mask_we), .rd_ok(rd_ok), .err(err_n)
  );

  mdir_request #(.LINES(LINES), .NUM_W(NUM_W)) u_req (
    .clk(clk), .rst(rst),
    .post(dev_post), .post_num(post_num),
    .clr(dev_clear), .clr_num(clr_num),
    .req_q(req_q), .req_n(req_n)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_lane
    logic lane_we;
    assign lane_we = mask_we && (dcpu == CPU_W'(c));

    mdir_cpu_lane #(.LINES(LINES), .NUM_W(NUM_W)) u_lane (
      .clk(clk), .rst(rst),
      .mask_we(lane_we), .wdata(reg_wdata), .req_n(req_n),
      .post(dev_post), .post_num(post_num),
      .mask_q(mask_arr[c]), .eff_q(eff_arr[c]),
      .irq(cpu_irq[c]), .raise(irq_raise[c]), .drop(irq_drop[c])
    );

    assign mask_flat[c*LINES +: LINES] = mask_arr[c];
    assign eff_flat[c*LINES +: LINES]  = eff_arr[c];
  end

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_REQ:  rd_val = req_q;
      SEL_MASK: rd_val = mask_arr[dcpu];
      SEL_EFF:  rd_val = eff_arr[dcpu];
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      reg_rdata <= rd_ok ? rd_val : '0;
      reg_err   <= err_n;
    end
  end
endmodule

// File: rtl/mdir_router_chk.sv
module mdir_router_chk #(
  parameter int NUM_CPUS = 4,
  parameter int LINES    = 64,
  parameter int ADDR_W   = 12,
  localparam int NUM_W   = $clog2(LINES)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      dev_post,
  input logic [NUM_W-1:0]          post_num,
  input logic                      dev_clear,
  input logic [NUM_W-1:0]          clr_num,
  input logic                      reg_rd,
  input logic                      reg_wr,
  input logic                      reg_full,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [LINES-1:0]          reg_rdata,
  input logic                      reg_err,
  input logic [NUM_CPUS-1:0]       cpu_irq,
  input logic [NUM_CPUS-1:0]       irq_raise,
  input logic [NUM_CPUS-1:0]       irq_drop,
  input logic [LINES-1:0]          req_q,
  input logic [NUM_CPUS*LINES-1:0] mask_flat,
  input logic [NUM_CPUS*LINES-1:0] eff_flat
);
  p_post_sets_r3: assert property (@(posedge clk) disable iff (rst)
    dev_post |=> req_q[$past(post_num)]);

  p_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    (dev_clear && !dev_post && !req_q[clr_num]) |=> (req_q == $past(req_q)));

  p_bad_size_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_full) |=> (reg_err && reg_rdata == '0));

  p_ro_write_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr[ADDR_W-1:6] == '0) |=> reg_err);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    p_eff_and_r4: assert property (@(posedge clk) disable iff (rst)
      eff_flat[c*LINES +: LINES] == (mask_flat[c*LINES +: LINES] & req_q));

    p_irq_level_r5: assert property (@(posedge clk) disable iff (rst)
      cpu_irq[c] == (|eff_flat[c*LINES +: LINES]));

    p_rise_has_raise_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(cpu_irq[c]) |-> irq_raise[c]);

    p_fall_has_drop_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(cpu_irq[c]) |-> irq_drop[c]);
  end
endmodule

bind mdir_router mdir_router_chk #(
  .NUM_CPUS(NUM_CPUS), .LINES(LINES), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/mdir_router_test.sv
module mdir_router_test;
  localparam int NC = 4;
  localparam int LN = 64;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dev_post = 1'b0;
  logic [5:0]    post_num = '0;
  logic          dev_clear = 1'b0;
  logic [5:0]    clr_num = '0;
  logic          reg_rd = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_full = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [LN-1:0] reg_wdata = '0;
  logic [LN-1:0] reg_rdata;
  logic          reg_err;
  logic [NC-1:0] cpu_irq;
  logic [NC-1:0] irq_raise;
  logic [NC-1:0] irq_drop;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [LN-1:0] m_mask [NC];
  logic [LN-1:0] m_req;

  mdir_router #(.NUM_CPUS(NC), .LINES(LN), .ADDR_W(AW)) uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [LN-1:0] act, input logic [LN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] a_mask(input int c);
    return AW'((8 + c) << 6);
  endfunction
  function automatic logic [AW-1:0] a_eff(input int c);
    return AW'((16 + c) << 6);
  endfunction

  // One event cycle: post, clear and mask write may coincide.
  task automatic ev(input bit p, input int pn, input bit cl, input int cn,
                    input bit w, input int wc, input logic [LN-1:0] wd, input string tag);
    logic [LN-1:0] oe [NC];
    logic [NC-1:0] e_irq, e_rai, e_drp;
    for (int c = 0; c < NC; c++) oe[c] = m_mask[c] & m_req;
    dev_post = p; post_num = 6'(pn); dev_clear = cl; clr_num = 6'(cn);
    reg_wr = w; reg_full = w; reg_addr = a_mask(wc); reg_wdata = wd;
    @(negedge clk);
    dev_post = 0; dev_clear = 0; reg_wr = 0; reg_full = 0;
    if (cl) m_req[cn] = 1'b0;
    if (p)  m_req[pn] = 1'b1;
    if (w)  m_mask[wc] = wd;
    for (int c = 0; c < NC; c++) begin
      logic [LN-1:0] ne;
      ne = m_mask[c] & m_req;
      e_irq[c] = |ne;
      e_rai[c] = (|(ne & ~oe[c])) || (p && m_mask[c][pn]);
      e_drp[c] = |(oe[c] & ~ne);
    end
    chk({tag, " irq"},   LN'(cpu_irq),   LN'(e_irq));
    chk({tag, " raise"}, LN'(irq_raise), LN'(e_rai));
    chk({tag, " drop"},  LN'(irq_drop),  LN'(e_drp));
  endtask

  task automatic rd(input logic [AW-1:0] addr, input bit full,
                    input logic [LN-1:0] exp, input bit exp_err, input string tag);
    reg_rd = 1; reg_full = full; reg_addr = addr;
    @(negedge clk);
    reg_rd = 0; reg_full = 0;
    chk({tag, " rdata"}, reg_rdata, exp);
    chk({tag, " err"},   LN'(reg_err), LN'(exp_err));
  endtask

  task automatic bad_wr(input logic [AW-1:0] addr, input bit full, input string tag);
    reg_wr = 1; reg_full = full; reg_addr = addr; reg_wdata = '1;
    @(negedge clk);
    reg_wr = 0; reg_full = 0;
    chk({tag, " err"},   LN'(reg_err), 1);
    chk({tag, " raise"}, LN'(irq_raise), 0);
    chk({tag, " drop"},  LN'(irq_drop), 0);
  endtask

  task automatic read_all(input string tag);
    rd(AW'(0), 1, m_req, 0, {tag, " req"});
    for (int c = 0; c < NC; c++) begin
      rd(a_mask(c), 1, m_mask[c], 0, {tag, " mask"});
      rd(a_eff(c), 1, m_mask[c] & m_req, 0, {tag, " eff"});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_req = '0;
    for (int c = 0; c < NC; c++) m_mask[c] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 irq",   LN'(cpu_irq), 0);
    chk("R1 raise", LN'(irq_raise), 0);
    chk("R1 drop",  LN'(irq_drop), 0);
    chk("R1 err",   LN'(reg_err), 0);
    read_all("R1");

    // R2: mask writes and readback
    ev(0, 0, 0, 0, 1, 0, '1, "R2 m0");
    ev(0, 0, 0, 0, 1, 1, {32{2'b01}}, "R2 m1");
    ev(0, 0, 0, 0, 1, 2, {{32{1'b1}}, 32'h0}, "R2 m2");
    ev(0, 0, 0, 0, 1, 3, '0, "R2 m3");
    read_all("R2");

    // R3 R5 R6: post every line
    for (int n = 0; n < LN; n++) begin
      ev(1, n, 0, 0, 0, 0, '0, "R3 R5 R6 post");
      if (n % 16 == 15) read_all("R4 sweep");
    end
    // R6: repost of a pending request still signals
    ev(1, 5, 0, 0, 0, 0, '0, "R6 repost");

    // R3 R7: clear even lines
    for (int n = 0; n < LN; n += 2) ev(0, 0, 1, n, 0, 0, '0, "R3 R7 clear");
    // R8: spurious clears change nothing
    for (int n = 0; n < LN; n += 2) ev(0, 0, 1, n, 0, 0, '0, "R8 spurious");
    rd(AW'(0), 1, {32{2'b10}}, 0, "R8 req");

    // R7: mask write withdraws, R6: mask write raises
    ev(0, 0, 0, 0, 1, 0, '0, "R7 mask off");
    ev(0, 0, 0, 0, 1, 0, 64'hF0, "R6 mask on");

    // R9: post and mask write together
    ev(1, 2, 0, 0, 1, 3, 64'h4, "R9 post+mask");
    rd(a_eff(3), 1, 64'h4, 0, "R9 eff3");

    // R3: same-number post and clear, bit ends set
    ev(1, 4, 1, 4, 0, 0, '0, "R3 post+clear");
    rd(AW'(0), 1, m_req, 0, "R3 req");
    chk("R3 bit4", LN'(m_req[4]), 1);
    // clear and post of different numbers together
    ev(1, 6, 1, 7, 0, 0, '0, "R3 mixed");
    read_all("R4 after mixed");

    // R10: writes to read-only registers
    bad_wr(AW'(0), 1, "R10 req");
    bad_wr(a_eff(0), 1, "R10 eff0");
    bad_wr(a_eff(3), 1, "R10 eff3");
    read_all("R10 unchanged");

    // R11: partial, misaligned and unmapped accesses
    rd(a_mask(1), 0, '0, 1, "R11 partial rd");
    bad_wr(a_mask(2), 0, "R11 partial wr");
    rd(AW'(30 << 6), 1, '0, 1, "R11 unmapped rd");
    bad_wr(AW'(30 << 6), 1, "R11 unmapped wr");
    rd(a_mask(0) | AW'(8), 1, '0, 1, "R11 misaligned rd");
    bad_wr(a_mask(1) | AW'(8), 1, "R11 misaligned wr");
    read_all("R11 unchanged");

    // R2: read data is the state before a same-cycle update
    reg_rd = 1; reg_full = 1; reg_addr = AW'(0); dev_post = 1; post_num = 6'd0;
    @(negedge clk);
    reg_rd = 0; reg_full = 0; dev_post = 0;
    chk("R2 pre-update read", reg_rdata, m_req);
    m_req[0] = 1'b1;
    rd(AW'(0), 1, m_req, 0, "R2 post-update read");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule